// File: doc/BRIEF.md
# Stack Push/Pop Micro-op Sequencer

This block turns one decoded compressed stack instruction (push, pop, pop-and-return, or pop-and-return with the return-value register cleared) into an ordered stream of plain micro-ops. Each micro-op is a single-register store or load, a stack-pointer add, a register clear or a return jump. The execution pipeline behind the block runs the micro-ops one by one. The sequencer takes a request holding the operation kind, a 4-bit register-list code and a 2-bit extra-frame field. It works out the frame size and then emits one micro-op per accepted handshake.

Both edges use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. On the output, the consumer can hold `uop_ready` low for any number of cycles. While it does, `uop_valid` stays high and the kind, register and offset fields do not change. The next micro-op appears only after a handshake. Offsets are two's complement byte offsets from the stack pointer as it stands when that micro-op runs.

Top module: `pushpop_seq`

## Requirements
- R1: After reset, `busy`, `uop_valid` and `illegal` are low and `req_ready` is high.
- R2: List code c selects the registers. Code 4 selects ra only. Codes 5 to 14 add s0 up to s(c-5). Code 15 selects ra and s0 to s11. Slot k is register x1 for k=0, x8 for k=1, x9 for k=2, and x(15+k) for k from 3 to 12.
- R3: A request with list code 0 to 3 is accepted. `illegal` is high for exactly the next cycle. No micro-op is issued and `busy` stays low.
- R4: Push (op 0) emits stores (kind 0), slot 0 first. Slot k is stored at offset -(k+1)*XLEN/8. The last micro-op is a stack-pointer add (kind 2) on x2 with offset -F.
- R5: Pop (op 1) emits loads (kind 1), slot 0 first. Slot k is loaded at offset F-(k+1)*XLEN/8. The last micro-op is a kind 2 add on x2 with offset +F.
- R6: Pop-and-return (op 2) emits the pop sequence and then a return (kind 4) on x1 with offset 0. The return is the final micro-op.
- R7: Pop-return-clear (op 3) emits the pop sequence, then a clear (kind 3) of x10 with offset 0, then the return as the final micro-op.
- R8: The frame size F is the save area (register count times XLEN/8) rounded up to a multiple of 16, plus 16 times the 2-bit extra field.
- R9: `uop_valid` is high in every busy cycle. While it is high and `uop_ready` is low, the micro-op fields hold steady.
- R10: `busy` rises the cycle after a legal request is accepted. It falls the cycle after the last micro-op handshake. `req_ready` is low while busy, and requests offered then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 push, 1 pop, 2 pop-return, 3 pop-return-clear |
| req_rlist | input | 4 | Register-list code |
| req_xtra | input | 2 | Extra frame in 16-byte units |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | One-cycle flag for a reserved list code |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 3 | 0 store, 1 load, 2 sp add, 3 clear, 4 return |
| uop_reg | output | 5 | Architectural register index |
| uop_offset | output | OFF_W | Byte offset or add amount, two's complement |

## Verification
The assertions assume that request fields matter only in a cycle where `req_valid` meets `req_ready`. They also assume the consumer may stall for any length of time, so every output check is taken relative to a handshake and never to a fixed cycle count. The stimulus covers every list code under every operation kind, reserved codes included. It changes the request fields at random while the block is busy. It stalls `uop_ready` at random rates, both zero and heavy, so the hold rule and the ignore-while-busy rule get exercised alongside the sequence contents.

// File: rtl/pushpop_pkg.sv
package pushpop_pkg;

  typedef enum logic [1:0] {
    SOP_PUSH    = 2'd0,
    SOP_POP     = 2'd1,
    SOP_POPRET  = 2'd2,
    SOP_POPRETZ = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    UK_STORE = 3'd0,
    UK_LOAD  = 3'd1,
    UK_SPADD = 3'd2,
    UK_ZERO  = 3'd3,
    UK_RET   = 3'd4
  } uop_kind_e;

  localparam logic [4:0] REG_RA = 5'd1;
  localparam logic [4:0] REG_SP = 5'd2;
  localparam logic [4:0] REG_A0 = 5'd10;

  // slot 0 = ra, slots 1..2 = s0..s1, slots 3..12 = s2..s11 (x18..x27)
  function automatic logic [4:0] slot_reg(input logic [3:0] k);
    logic [4:0] r;
    case (k)
      4'd0:    r = REG_RA;
      4'd1:    r = 5'd8;
      4'd2:    r = 5'd9;
      default: r = 5'({1'b0, k}) + 5'd15;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pushpop_decode.sv
module pushpop_decode #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic [3:0]       rlist,
  input  logic [1:0]       xtra,
  output logic             legal,
  output logic [3:0]       nregs,
  output logic [OFF_W-1:0] frame
);
  localparam logic [OFF_W-1:0] XB_W  = OFF_W'(XLEN / 8);
  localparam logic [OFF_W-1:0] ALIGN = OFF_W'(15);

  logic [OFF_W-1:0] save_bytes;
  logic [OFF_W-1:0] save_round;

  always_comb begin
    legal = (rlist >= 4'd4);
    if (rlist == 4'd15)   nregs = 4'd13;
    else if (legal)       nregs = rlist - 4'd3;
    else                  nregs = 4'd0;
    save_bytes = OFF_W'(nregs) * XB_W;
    save_round = (save_bytes + ALIGN) & ~ALIGN;
    frame      = save_round + (OFF_W'(xtra) << 4);
  end

  always_comb begin
    if (legal) begin
      AST_FRAME_ALIGNED: assert (frame[3:0] == 4'd0); // R8
      AST_FRAME_COVERS: assert (frame >= save_bytes); // R8
    end
  end

endmodule

// File: rtl/pushpop_uopgen.sv
module pushpop_uopgen
  import pushpop_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic [4:0]       step,
  input  stk_op_e          op,
  input  logic [3:0]       nregs,
  input  logic [OFF_W-1:0] frame,
  output uop_kind_e        kind,
  output logic [4:0]       rnum,
  output logic [OFF_W-1:0] offset,
  output logic             last
);
  localparam logic [OFF_W-1:0] XB_W = OFF_W'(XLEN / 8);

  logic [4:0]       n5;
  logic [4:0]       total;
  logic [OFF_W-1:0] slot_bytes;

  always_comb begin
    n5    = {1'b0, nregs};
    total = n5 + 5'd1;
    if (op == SOP_POPRET)  total = n5 + 5'd2;
    if (op == SOP_POPRETZ) total = n5 + 5'd3;
    last = (step == total - 5'd1);
    slot_bytes = (OFF_W'(step) + OFF_W'(1)) * XB_W;
  end

  always_comb begin
    kind   = UK_SPADD;
    rnum   = REG_SP;
    offset = '0;
    if (step < n5) begin
      rnum = slot_reg(step[3:0]);
      if (op == SOP_PUSH) begin
        kind   = UK_STORE;
        offset = '0 - slot_bytes;
      end else begin
        kind   = UK_LOAD;
        offset = frame - slot_bytes;
      end
    end else if (step == n5) begin
      kind   = UK_SPADD;
      rnum   = REG_SP;
      offset = (op == SOP_PUSH) ? ('0 - frame) : frame;
    end else if (op == SOP_POPRETZ && step == n5 + 5'd1) begin
      kind = UK_ZERO;
      rnum = REG_A0;
    end else begin
      kind = UK_RET;
      rnum = REG_RA;
    end
  end

endmodule

// File: rtl/pushpop_ctrl.sv
module pushpop_ctrl
  import pushpop_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  stk_op_e          req_op,
  input  logic             dec_legal,
  input  logic [3:0]       dec_nregs,
  input  logic [OFF_W-1:0] dec_frame,
  input  logic             uop_ready,
  input  logic             seq_last,
  output logic             req_ready,
  output logic             busy,
  output logic             illegal,
  output logic             uop_valid,
  output logic [4:0]       step,
  output stk_op_e          op_q,
  output logic [3:0]       nregs_q,
  output logic [OFF_W-1:0] frame_q
);
  logic take;
  logic fire;

  assign req_ready = !busy;
  assign uop_valid = busy;
  assign take      = req_valid && req_ready;
  assign fire      = uop_valid && uop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      illegal <= 1'b0;
      step    <= '0;
      op_q    <= SOP_PUSH;
      nregs_q <= '0;
      frame_q <= '0;
    end else begin
      illegal <= take && !dec_legal;
      if (take && dec_legal) begin
        busy    <= 1'b1;
        step    <= '0;
        op_q    <= req_op;
        nregs_q <= dec_nregs;
        frame_q <= dec_frame;
      end else if (fire) begin
        if (seq_last) begin
          busy <= 1'b0;
          step <= '0;
        end else begin
          step <= step + 5'd1;
        end
      end
    end
  end

  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy); // R3
  AST_LEGAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec_legal |=> busy && step == 5'd0); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && seq_last |=> !busy); // R10
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !seq_last |=> busy && step == $past(step) + 5'd1); // R9

endmodule

// File: rtl/pushpop_seq.sv
module pushpop_seq
  import pushpop_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [3:0]       req_rlist,
  input  logic [1:0]       req_xtra,
  output logic             busy,
  output logic             illegal,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [2:0]       uop_kind,
  output logic [4:0]       uop_reg,
  output logic [OFF_W-1:0] uop_offset
);
  logic             dec_legal;
  logic [3:0]       dec_nregs;
  logic [OFF_W-1:0] dec_frame;
  logic [4:0]       step;
  stk_op_e          op_q;
  logic [3:0]       nregs_q;
  logic [OFF_W-1:0] frame_q;
  logic             seq_last;
  uop_kind_e        kind;

  pushpop_decode #(.XLEN(XLEN), .OFF_W(OFF_W)) u_dec (
    .rlist (req_rlist),
    .xtra  (req_xtra),
    .legal (dec_legal),
    .nregs (dec_nregs),
    .frame (dec_frame)
  );

  pushpop_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (stk_op_e'(req_op)),
    .dec_legal (dec_legal),
    .dec_nregs (dec_nregs),
    .dec_frame (dec_frame),
    .uop_ready (uop_ready),
    .seq_last  (seq_last),
    .req_ready (req_ready),
    .busy      (busy),
    .illegal   (illegal),
    .uop_valid (uop_valid),
    .step      (step),
    .op_q      (op_q),
    .nregs_q   (nregs_q),
    .frame_q   (frame_q)
  );

  pushpop_uopgen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_gen (
    .step   (step),
    .op     (op_q),
    .nregs  (nregs_q),
    .frame  (frame_q),
    .kind   (kind),
    .rnum   (uop_reg),
    .offset (uop_offset),
    .last   (seq_last)
  );

  assign uop_kind = kind;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_reg)
      && $stable(uop_offset)); // R9
  AST_RET_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && uop_kind == 3'd4 |=> !busy); // R6
  AST_CLEAR_THEN_RET: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && uop_kind == 3'd3 |=> uop_valid && uop_kind == 3'd4); // R7
  AST_NO_UOP_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !uop_valid); // R3
  AST_SPADD_ON_SP: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind == 3'd2 |-> uop_reg == 5'd2); // R4

endmodule

// File: tb/sim_pushpop_seq.sv
module sim_pushpop_seq;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 32;
  localparam int OFF_W = 12;
  localparam int XB    = XLEN / 8;
  localparam int MASK  = (1 << OFF_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [3:0] req_rlist = '0;
  logic [1:0] req_xtra = '0;
  logic busy, illegal, uop_valid;
  logic uop_ready = 1'b0;
  logic [2:0] uop_kind;
  logic [4:0] uop_reg;
  logic [OFF_W-1:0] uop_offset;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  int ek[16];
  int er[16];
  int eo[16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pushpop_seq #(.XLEN(XLEN), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rlist(req_rlist), .req_xtra(req_xtra),
    .busy(busy), .illegal(illegal), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_kind(uop_kind), .uop_reg(uop_reg), .uop_offset(uop_offset)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int slot_to_reg(input int k);
    if (k == 0) return 1;
    if (k == 1) return 8;
    if (k == 2) return 9;
    return 15 + k;
  endfunction

  function automatic int count_regs(input int code);
    return (code == 15) ? 13 : code - 3;
  endfunction

  function automatic int frame_of(input int code, input int xtra);
    int save;
    save = count_regs(code) * XB;
    if (save % 16 != 0) save = (save / 16 + 1) * 16;
    return save + 16 * xtra;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // expected micro-op list, returns its length
  function automatic int expand(input int op, input int code, input int xtra);
    int n, f, c;
    n = count_regs(code);
    f = frame_of(code, xtra);
    c = 0;
    for (int k = 0; k < n; k++) begin
      ek[c] = (op == 0) ? 0 : 1;
      er[c] = slot_to_reg(k);
      eo[c] = ((op == 0) ? -(k + 1) * XB : f - (k + 1) * XB) & MASK;
      c++;
    end
    ek[c] = 2; er[c] = 2; eo[c] = ((op == 0) ? -f : f) & MASK; c++;
    if (op == 3) begin ek[c] = 3; er[c] = 10; eo[c] = 0; c++; end
    if (op >= 2) begin ek[c] = 4; er[c] = 1; eo[c] = 0; c++; end
    return c;
  endfunction

  task automatic run_req(input int op, input int code, input int xtra, input int stall_pct);
    int cnt, idx, guard;
    bit prev_stall;
    int pk, pr, po;
    string t;
    t = tag_of(op);
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_op = 2'(op); req_rlist = 4'(code); req_xtra = 2'(xtra);
    @(negedge clk);
    // offered while busy: must be ignored (R10)
    req_op = 2'($urandom); req_rlist = 4'($urandom); req_xtra = 2'($urandom);
    if (code < 4) begin
      req_valid = 1'b0;
      check(illegal == 1'b1, "R3", "illegal flag", illegal, 1);
      check(busy == 1'b0 && uop_valid == 1'b0, "R3", "no uop on reserved code", uop_valid, 0);
      @(negedge clk);
      check(illegal == 1'b0, "R3", "illegal one cycle", illegal, 0);
      check(uop_valid == 1'b0, "R3", "still no uop", uop_valid, 0);
      return;
    end
    cnt = expand(op, code, xtra);
    check(busy == 1'b1, "R10", "busy after accept", busy, 1);
    check(illegal == 1'b0, "R3", "no flag on legal code", illegal, 0);
    idx = 0; guard = 0; prev_stall = 1'b0; pk = 0; pr = 0; po = 0;
    while (idx < cnt && guard < 2000) begin
      guard++;
      check(uop_valid == 1'b1, "R9", "valid while busy", uop_valid, 1);
      check(req_ready == 1'b0, "R10", "not ready while busy", req_ready, 0);
      if (prev_stall) begin
        check(int'(uop_kind) == pk && int'(uop_reg) == pr && int'(uop_offset) == po,
              "R9", "fields held during stall", int'(uop_offset), po);
      end
      uop_ready = (($urandom % 100) >= stall_pct);
      if (uop_valid && uop_ready) begin
        check(int'(uop_kind) == ek[idx], t, "kind", int'(uop_kind), ek[idx]);
        check(int'(uop_reg) == er[idx], (idx < count_regs(code)) ? "R2" : t, "reg",
              int'(uop_reg), er[idx]);
        check(int'(uop_offset) == eo[idx], (ek[idx] == 2) ? "R8" : t, "offset",
              int'(uop_offset), eo[idx]);
        idx++;
        if (idx == cnt) req_valid = 1'b0;
      end
      prev_stall = uop_valid && !uop_ready;
      pk = int'(uop_kind); pr = int'(uop_reg); po = int'(uop_offset);
      @(negedge clk);
    end
    uop_ready = 1'b0;
    req_valid = 1'b0;
    check(idx == cnt, t, "micro-op count", idx, cnt);
    check(busy == 1'b0 && uop_valid == 1'b0, "R10", "idle after last", busy, 0);
    check(req_ready == 1'b1, "R10", "ready after last", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(uop_valid == 1'b0, "R1", "uop_valid after reset", uop_valid, 0);
    check(illegal == 1'b0, "R1", "illegal after reset", illegal, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

    // directed: every op, every list code, no stall
    for (int op = 0; op < 4; op++)
      for (int code = 0; code < 16; code++)
        run_req(op, code, code % 4, 0);

    // directed: largest list, heavy stall, max extra frame
    for (int op = 0; op < 4; op++) run_req(op, 15, 3, 70);
    // smallest list, zero extra
    for (int op = 0; op < 4; op++) run_req(op, 4, 0, 40);

    // constrained random
    for (int i = 0; i < 300; i++)
      run_req(int'($urandom % 4), int'($urandom % 16), int'($urandom % 4),
              int'($urandom % 60));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule